// File: doc/BRIEF.md
# Multiplexer-Based Internal Bus Resolver

This block stands in for an on-chip shared bus that would otherwise be built from tri-state buffers. Each of N drivers presents a data word together with its own enable bit. The block merges them into one resolved word using plain gating logic, so no Z or X value can ever reach the bus.

When exactly one enable is high, the bus carries that driver's word. When several enables are high, any bit on which an enabled driver drives a zero goes low, giving a wired-AND result. When no enable is high, the bus settles to all ones instead of floating.

Two flags accompany the word:
- a contention flag, set when two or more drivers are enabled;
- an idle flag, set when no driver is enabled.

A parameter selects either a purely combinational output or one output register stage. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `bus_res_top`

## Requirements
- R1: Driver i presents its word on bits i*W to i*W+W-1 of `drv_data` and is enabled by bit i of `drv_en`. With exactly one enable bit high, `bus_q` equals that driver's word.
- R2: With two or more enable bits high, each bit of `bus_q` is 0 if any enabled driver drives 0 on that bit, and 1 otherwise.
- R3: With no enable bit high, `bus_q` is all ones.
- R4: The data word of a driver whose enable is low has no effect on `bus_q`.
- R5: `contention_q` is 1 exactly when two or more enable bits are high.
- R6: `idle_q` is 1 exactly when no enable bit is high. `idle_q` and `contention_q` are never both 1.
- R7: With OUT_REG=1 (the default), the outputs reflect the inputs present before the previous rising clock edge. With OUT_REG=0 they follow the inputs in the same cycle.
- R8: While the block is in reset, `bus_q` is all ones, `idle_q` is 1 and `contention_q` is 0. After `rst_n` rises, the internal reset stays active through two more rising edges. The outputs therefore first track the inputs after the third rising edge following the release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| drv_data | input | N*W | Driver data words, driver i in slice i*W +: W |
| drv_en | input | N | Per-driver enable bits |
| bus_q | output | W | Resolved bus word |
| contention_q | output | 1 | Two or more drivers enabled |
| idle_q | output | 1 | No driver enabled |

## Verification
With the default registered output, the word and both flags for a given input vector are due one rising edge after that vector is applied. The bench therefore drives each vector on a falling edge and compares all three outputs at the next falling edge, after exactly one capture. After reset release, the bench counts three rising edges before the first tracked result. It checks the reset value at the second falling edge and the tracked value at the third. The bound properties use the same one-cycle offset through `$past` and are gated off until the internal reset has been released for at least one edge.

// File: rtl/bus_res_pkg.sv
package bus_res_pkg;

  typedef struct packed {
    logic contention;
    logic idle;
  } bus_flags_t;

  localparam bus_flags_t FLAGS_RESET = '{contention: 1'b0, idle: 1'b1};

endpackage

// File: rtl/bus_res_rst_sync.sv
module bus_res_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bus_res_merge.sv
module bus_res_merge #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N*W-1:0] data,
  input  logic [N-1:0]   en,
  output logic [W-1:0]   bus
);
  logic [W-1:0] acc [N+1];

  assign acc[0] = '1;

  for (genvar g = 0; g < N; g++) begin : g_drv
    // a disabled driver contributes all ones to the AND chain
    assign acc[g+1] = acc[g] & (data[g*W +: W] | {W{~en[g]}});
  end

  assign bus = acc[N];
endmodule

// File: rtl/bus_res_flags.sv
module bus_res_flags
  import bus_res_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] en,
  output bus_flags_t   flags
);
  logic [N:0] seen_one;
  logic [N:0] seen_two;

  assign seen_one[0] = 1'b0;
  assign seen_two[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_scan
    assign seen_one[g+1] = seen_one[g] | en[g];
    assign seen_two[g+1] = seen_two[g] | (seen_one[g] & en[g]);
  end

  assign flags.idle       = ~seen_one[N];
  assign flags.contention = seen_two[N];
endmodule

// File: rtl/bus_res_top.sv
module bus_res_top
  import bus_res_pkg::*;
#(
  parameter int N       = 4,
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*W-1:0] drv_data,
  input  logic [N-1:0]   drv_en,
  output logic [W-1:0]   bus_q,
  output logic           contention_q,
  output logic           idle_q
);
  localparam int SYNC_STAGES = 2;

  logic       rst_core_n;
  logic [W-1:0] bus_d;
  bus_flags_t   flags_d;

  bus_res_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  bus_res_merge #(.N(N), .W(W)) u_merge (
    .data (drv_data),
    .en   (drv_en),
    .bus  (bus_d)
  );

  bus_res_flags #(.N(N)) u_flags (
    .en    (drv_en),
    .flags (flags_d)
  );

  if (OUT_REG) begin : g_reg
    logic [W-1:0] bus_r;
    bus_flags_t   flags_r;

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) begin
        bus_r   <= '1;
        flags_r <= FLAGS_RESET;
      end else begin
        bus_r   <= bus_d;
        flags_r <= flags_d;
      end
    end

    assign bus_q        = bus_r;
    assign contention_q = flags_r.contention;
    assign idle_q       = flags_r.idle;
  end else begin : g_comb
    always_comb begin
      if (!rst_core_n) begin
        bus_q        = '1;
        contention_q = FLAGS_RESET.contention;
        idle_q       = FLAGS_RESET.idle;
      end else begin
        bus_q        = bus_d;
        contention_q = flags_d.contention;
        idle_q       = flags_d.idle;
      end
    end
  end
endmodule

// File: rtl/bus_res_chk.sv
module bus_res_chk #(
  parameter int N       = 4,
  parameter int W       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic           clk,
  input logic           rst_core_n,
  input logic [N*W-1:0] drv_data,
  input logic [N-1:0]   drv_en,
  input logic [W-1:0]   bus_q,
  input logic           contention_q,
  input logic           idle_q
);
  // R6: flags are mutually exclusive
  assert_flags_exclusive_R6: assert property (@(posedge clk)
    !(idle_q && contention_q));

  // R8: reset values, once reset has been held across an edge
  assert_reset_values_R8: assert property (@(posedge clk)
    (!rst_core_n && $past(!rst_core_n)) |-> (bus_q == '1 && idle_q && !contention_q));

  if (OUT_REG) begin : g_seq
    // R3 R7: idle bus is all ones one edge later
    assert_idle_ones_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
      ($past(rst_core_n) && $past(drv_en) == '0) |-> (bus_q == '1));

    // R5 R7
    assert_contention_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
      $past(rst_core_n) |-> (contention_q == ($countones($past(drv_en)) >= 2)));

    // R6 R7
    assert_idle_flag_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
      $past(rst_core_n) |-> (idle_q == ($past(drv_en) == '0)));

    for (genvar i = 0; i < N; i++) begin : g_drv
      // R1 R4: sole driver owns the bus
      assert_sole_driver_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
        ($past(rst_core_n) && $past(drv_en) == (N'(1) << i))
        |-> (bus_q == $past(drv_data[i*W +: W])));

      // R2: no 1 where an enabled driver drove 0
      assert_wired_and_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
        ($past(rst_core_n) && $past(drv_en[i]))
        |-> ((bus_q & ~$past(drv_data[i*W +: W])) == '0));
    end
  end else begin : g_comb
    // R3 R7
    assert_idle_ones_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
      (drv_en == '0) |-> (bus_q == '1));

    // R5
    assert_contention_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
      contention_q == ($countones(drv_en) >= 2));

    // R6
    assert_idle_flag_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
      idle_q == (drv_en == '0));

    for (genvar i = 0; i < N; i++) begin : g_drv
      // R2
      assert_wired_and_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
        drv_en[i] |-> ((bus_q & ~drv_data[i*W +: W]) == '0));
    end
  end
endmodule

bind bus_res_top bus_res_chk #(.N(N), .W(W), .OUT_REG(OUT_REG)) u_chk (
  .clk          (clk),
  .rst_core_n   (rst_core_n),
  .drv_data     (drv_data),
  .drv_en       (drv_en),
  .bus_q        (bus_q),
  .contention_q (contention_q),
  .idle_q       (idle_q)
);

// File: tb/tb_bus_res_top.sv
module tb_bus_res_top;
  localparam int N = 4;
  localparam int W = 8;
  localparam int WATCHDOG_CYCLES = 20000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N*W-1:0] drv_data = '0;
  logic [N-1:0]   drv_en = '0;
  logic [W-1:0]   bus_q;
  logic           contention_q;
  logic           idle_q;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_res_top #(.N(N), .W(W), .OUT_REG(1'b1)) dut (
    .clk (clk), .rst_n (rst_n), .drv_data (drv_data), .drv_en (drv_en),
    .bus_q (bus_q), .contention_q (contention_q), .idle_q (idle_q)
  );

  // model: bit is high unless some enabled driver pulls it low
  function automatic logic [W-1:0] exp_bus(input logic [N*W-1:0] d, input logic [N-1:0] e);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) begin
      r[b] = 1'b1;
      for (int i = 0; i < N; i++) if (e[i] && !d[i*W+b]) r[b] = 1'b0;
    end
    return r;
  endfunction

  function automatic int count_en(input logic [N-1:0] e);
    int c = 0;
    for (int i = 0; i < N; i++) if (e[i]) c++;
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [N-1:0] e);
    int c = count_en(e);
    if (c == 0) return "R3";
    if (c == 1) return "R1";
    return "R2";
  endfunction

  // drive on a falling edge, compare after one capture edge (R7)
  task automatic apply(input logic [N-1:0] e, input logic [N*W-1:0] d);
    int c = count_en(e);
    drv_en   = e;
    drv_data = d;
    @(negedge clk);
    check({req_of(e), "/R7 bus"}, 32'(bus_q), 32'(exp_bus(d, e)));
    check("R5 contention", 32'(contention_q), 32'(c >= 2));
    check("R6 idle", 32'(idle_q), 32'(c == 0));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    drv_en   = 4'b0001;
    drv_data = '0;
    repeat (3) @(negedge clk);
    check("R8 bus in reset", 32'(bus_q), 32'(8'hFF));
    check("R8 idle in reset", 32'(idle_q), 32'd1);
    check("R8 contention in reset", 32'(contention_q), 32'd0);

    rst_n = 1'b1;                     // released at a falling edge
    @(negedge clk);
    check("R8 held after 1 edge", 32'(bus_q), 32'(8'hFF));
    @(negedge clk);
    check("R8 held after 2 edges", 32'(idle_q), 32'd1);
    @(negedge clk);
    check("R8 tracking after 3 edges", 32'(bus_q), 32'(8'h00));
    check("R8 idle low after 3 edges", 32'(idle_q), 32'd0);

    // R4: disabled drivers all drive zero, sole driver A5
    apply(4'b0100, {8'h00, 8'hA5, 8'h00, 8'h00});
    // R4: disabled drivers drive ones, sole driver 00
    apply(4'b1000, {8'h00, 8'hFF, 8'hFF, 8'hFF});
    // R2: all enabled, complementary data -> 0
    apply(4'b1111, {8'hF0, 8'h0F, 8'hFF, 8'hFF});
    // R2: agreeing ones survive contention
    apply(4'b0011, {8'h00, 8'h00, 8'hC3, 8'hC7});
    // R3: nobody drives, data ignored
    apply(4'b0000, {8'h00, 8'h00, 8'h00, 8'h00});

    // sweep every enable combination with random data
    for (int e = 0; e < (1 << N); e++) begin
      apply(N'(e), {$urandom, $urandom} [N*W-1:0]);
    end

    for (int k = 0; k < 300; k++) begin
      apply(N'($urandom), {$urandom, $urandom} [N*W-1:0]);
    end

    summary();
  end
endmodule